// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block turns a serial bit stream into a parallel word. Bits enter a chain of flip-flops on the rising edge of a shift clock. A second, independent clock copies the whole chain at once into a holding register, which drives the parallel pins. The parallel pins can be switched to high impedance, so several units can share one bus.

The last stage of the chain is also brought out as a serial output. Wiring it to the serial input of the next unit turns N units into one chain of N times the width. An active-low clear empties the chain at once, without a clock. The clear is released in step with the shift clock through a short synchronizer. It never touches the holding register. If one signal drives both clocks, the holding register always shows the chain as it was one edge earlier.

Top module: `sipo_latched_out`

## Requirements
- R1: On each rising edge of `sclk_i`, with the chain out of clear, stage 1 (`par` bit 0 after transfer) takes `ser_i` and stage k takes the old value of stage k-1, for k from 2 to WIDTH.
- R2: On each rising edge of `hclk_i`, the holding register takes the chain contents. Shift edges alone never change what the parallel outputs show.
- R3: While `clr_n_i` is low, every chain stage is 0 and `ser_o` is 0, with or without clock edges. Shift edges during clear leave the chain at 0.
- R4: After `clr_n_i` rises, the first CLR_SYNC_STAGES (default 2) shift edges still leave the chain at 0. The edge after them shifts normally.
- R5: The clear leaves the holding register unchanged. A transfer made after a clear loads all zeros.
- R6: With `oe_n_i` high, all WIDTH parallel outputs are high impedance. With it low, they show the holding register, with bit i holding stage i+1.
- R7: Toggling `oe_n_i` changes the contents of neither the chain nor the holding register.
- R8: `ser_o` is the last chain stage at all times, whatever `oe_n_i` is. Two chained units act as one 2·WIDTH-bit chain.
- R9: When `sclk_i` and `hclk_i` rise together, the holding register takes the chain contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_i | input | 1 | Serial data into stage 1 |
| sclk_i | input | 1 | Shift clock, rising edge |
| hclk_i | input | 1 | Holding-register clock, rising edge |
| clr_n_i | input | 1 | Asynchronous chain clear, active low |
| oe_n_i | input | 1 | Parallel output enable, active low |
| par_o | output | WIDTH | Tri-state parallel outputs from the holding register |
| ser_o | output | 1 | Last chain stage, for cascading |

## Verification
A wrong chain state shows at `ser_o` within WIDTH minus k shift edges for a fault in stage k. Through the cascade it shows at the second unit's `ser_o` WIDTH edges later. It shows on the parallel bus right after the next holding-clock edge. A wrong holding value, or a driver left on while disabled, appears on the shared pulled-down bus as soon as the other unit is enabled or both units are off. An early or late release of the clear shifts every later serial bit by one position, so it shows on the first transfer after the release.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  parameter int unsigned SIPO_DEF_WIDTH = 8;
  parameter int unsigned SIPO_DEF_SYNC  = 2;
endpackage

// File: rtl/sipo_rel_sync.sv
// Asserts its output with the asynchronous clear and releases it after
// STAGES rising edges of the shift clock.
module sipo_rel_sync #(
  parameter int unsigned STAGES = sipo_pkg::SIPO_DEF_SYNC
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign rst_n_o = arst_n_i;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;

      always_comb begin
        sync_d    = sync_q << 1;
        sync_d[0] = 1'b1;
      end

      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) sync_q <= '0;
        else           sync_q <= sync_d;
      end

      assign rst_n_o = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sipo_shift_stage.sv
// Serial chain: index 0 is stage 1, index W-1 is the last stage.
module sipo_shift_stage #(
  parameter int unsigned W = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = {q_o[W-2:0], ser_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_o <= '0;
    else          q_o <= q_d;
  end

  // R1: one-position move per shift edge
  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_n_i |=> q_o == {$past(q_o[W-2:0]), $past(ser_i)});
endmodule

// File: rtl/sipo_hold_stage.sv
// Holding register, no reset by design.
module sipo_hold_stage #(
  parameter int unsigned W = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = d_i;
  end

  always_ff @(posedge clk_i) begin
    q_o <= q_d;
  end
endmodule

// File: rtl/sipo_latched_out.sv
module sipo_latched_out #(
  parameter int unsigned WIDTH           = sipo_pkg::SIPO_DEF_WIDTH,
  parameter int unsigned CLR_SYNC_STAGES = sipo_pkg::SIPO_DEF_SYNC
) (
  input  logic             ser_i,
  input  logic             sclk_i,
  input  logic             hclk_i,
  input  logic             clr_n_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             shift_rst_n;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  sipo_rel_sync #(.STAGES(CLR_SYNC_STAGES)) u_rel (
    .clk_i    (sclk_i),
    .arst_n_i (clr_n_i),
    .rst_n_o  (shift_rst_n)
  );

  sipo_shift_stage #(.W(WIDTH)) u_shift (
    .clk_i   (sclk_i),
    .rst_n_i (shift_rst_n),
    .ser_i   (ser_i),
    .q_o     (shift_q)
  );

  sipo_hold_stage #(.W(WIDTH)) u_hold (
    .clk_i (hclk_i),
    .d_i   (shift_q),
    .q_o   (hold_q)
  );

  assign ser_o = shift_q[LAST];

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_drv
      assign par_o[g] = oe_n_i ? 1'bz : hold_q[g];
    end
  endgenerate

  // R2: each transfer holds the chain value seen at that edge
  p_copy_r2: assert property (@(posedge hclk_i) disable iff (!clr_n_i)
    1'b1 |=> hold_q == $past(shift_q));

  // R3: chain empty whenever the clear pin is low
  always @(posedge hclk_i) begin
    if (!clr_n_i) begin
      p_clear_zero_r3: assert (shift_q == '0);
    end
  end

  // R4: at the release edge the chain is still empty
  p_release_clean_r4: assert property (@(posedge sclk_i) disable iff (!clr_n_i)
    $rose(shift_rst_n) |-> shift_q == '0);
endmodule

// File: tb/sipo_latched_out_tb.sv
module sipo_latched_out_tb;
  localparam int W    = 8;
  localparam int SYNC = 2;
  localparam int WDOG = 50000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic ser_in, sclk, hclk, clr_n, oe_a, oe_b;
  logic ser_a, ser_b;
  wire [W-1:0] bus;

  sipo_latched_out #(.WIDTH(W), .CLR_SYNC_STAGES(SYNC)) u_dut (
    .ser_i(ser_in), .sclk_i(sclk), .hclk_i(hclk), .clr_n_i(clr_n),
    .oe_n_i(oe_a), .par_o(bus), .ser_o(ser_a));

  sipo_latched_out #(.WIDTH(W), .CLR_SYNC_STAGES(SYNC)) u_dut_b (
    .ser_i(ser_a), .sclk_i(sclk), .hclk_i(hclk), .clr_n_i(clr_n),
    .oe_n_i(oe_b), .par_o(bus), .ser_o(ser_b));

  generate
    for (genvar g = 0; g < W; g++) begin : g_pd
      pulldown (bus[g]);
    end
  endgenerate

  // reference model: chain[k] is stage k+1 of the 16-stage cascade
  logic [2*W-1:0] chain;
  logic [W-1:0]   hold_a, hold_b;
  int rel_cnt;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic expect_eq(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_shift(logic b);
    if (!clr_n) chain = '0;
    else if (rel_cnt > 0) begin chain = '0; rel_cnt--; end
    else chain = {chain[2*W-2:0], b};
  endtask

  task automatic check_ser(string tag);
    expect_eq({tag, " ser_a"}, {15'd0, ser_a}, {15'd0, chain[W-1]});
    expect_eq({tag, " ser_b"}, {15'd0, ser_b}, {15'd0, chain[2*W-1]});
  endtask

  task automatic sh(logic b, string tag);
    ser_in = b; #1;
    sclk = 1'b1; model_shift(b);
    #2 sclk = 1'b0; #1;
    check_ser(tag);
  endtask

  task automatic hold_pulse();
    #1 hclk = 1'b1;
    hold_a = chain[W-1:0]; hold_b = chain[2*W-1:W];
    #2 hclk = 1'b0; #1;
  endtask

  task automatic both_pulse(logic b, string tag);
    ser_in = b; #1;
    sclk = 1'b1; hclk = 1'b1;
    hold_a = chain[W-1:0]; hold_b = chain[2*W-1:W];
    model_shift(b);
    #2 sclk = 1'b0; hclk = 1'b0; #1;
    check_ser(tag);
  endtask

  task automatic check_bus(string tag);
    oe_a = 1'b0; oe_b = 1'b1; #2;
    expect_eq({tag, " bus unit A"}, {8'd0, bus}, {8'd0, hold_a});
    oe_a = 1'b1; oe_b = 1'b0; #2;
    expect_eq({tag, " bus unit B"}, {8'd0, bus}, {8'd0, hold_b});
    oe_a = 1'b1; oe_b = 1'b1; #2;
    expect_eq({tag, " bus both off (R6)"}, {8'd0, bus}, 16'd0);
  endtask

  task automatic do_clear(string tag);
    #1 clr_n = 1'b0; chain = '0; rel_cnt = SYNC; #2;
    check_ser(tag);
  endtask

  initial begin
    sclk = 0; hclk = 0; ser_in = 0; oe_a = 1; oe_b = 1; clr_n = 0;
    chain = '0; rel_cnt = SYNC; hold_a = '0; hold_b = '0;
    #10;
    check_ser("R3 reset");
    expect_eq("R6 bus idle", {8'd0, bus}, 16'd0);
    #1 clr_n = 1'b1; #2;

    // R4: two edges after release are swallowed
    sh(1'b1, "R4 edge1"); sh(1'b1, "R4 edge2"); sh(1'b1, "R4 edge3");
    hold_pulse();
    check_bus("R4 after release");

    // R1/R8: 16-bit pattern through the cascade
    for (int i = 15; i >= 0; i--) sh(logic'(16'hA5C3 >> i), "R1 R8 shift");
    hold_pulse();
    check_bus("R2 R6 transfer");

    // R2: shifting alone leaves outputs alone
    sh(1'b0, "R1 extra"); sh(1'b1, "R1 extra"); sh(1'b1, "R1 extra");
    check_bus("R2 no transfer");

    // R7/R8: output enable toggles touch nothing stored
    for (int i = 0; i < 10; i++) begin
      oe_a = logic'(i); oe_b = logic'(i >> 1); #1;
      check_ser("R8 oe independent");
    end
    oe_a = 1; oe_b = 1;
    check_bus("R7 hold kept");
    for (int i = 0; i < 8; i++) sh(logic'(8'h6B >> i), "R7 chain kept");
    hold_pulse();
    check_bus("R7 after shifts");

    // R3/R5: clear in mid-stream
    for (int i = 0; i < 5; i++) sh(logic'(i & 1), "R1 pre-clear");
    do_clear("R3 clear mid-shift");
    sh(1'b1, "R3 shift during clear");
    check_bus("R5 hold survives clear");
    #1 clr_n = 1'b1; #2;
    hold_pulse();
    check_bus("R5 zero transfer");
    sh(1'b1, "R4 rel1"); sh(1'b0, "R4 rel2");
    for (int i = 0; i < 12; i++) sh(logic'(12'hD39 >> i), "R1 refill");
    hold_pulse();
    check_bus("R1 refill");

    // R9: tied clocks
    for (int i = 0; i < 6; i++) begin
      both_pulse(logic'(6'h2D >> i), "R9 tied");
      check_bus("R9 tied");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= WDOG || done);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule